// File: doc/BRIEF.md
# Per-Endpoint Byte FIFO Bridge Between CPU Registers and a USB Packet Engine

This block sits between a USB device packet engine and a CPU register bus. Every endpoint owns one small byte FIFO per supported direction. For device-to-host traffic the CPU pushes bytes through a register and the engine drains them when the host polls. For host-to-device traffic the engine fills the FIFO from received data and the CPU peeks and pops bytes through a register.

Each endpoint also carries a handshake selection (ACK, NAK or STALL), a pending flag that latches packet completion, and an interrupt enable. Each endpoint's pending flag gated by its enable forms a per-endpoint interrupt line, and an OR of those lines forms one summary interrupt. While a completion is pending, the engine is told to answer with NAK so that the CPU can service the FIFO first. The serial layer, CRC and token decoding are outside the block. The engine presents an endpoint index, a direction and single-cycle strobes.

The endpoint count, FIFO depth and per-endpoint direction set are parameters. The default is three endpoints: endpoint 0 bidirectional, endpoint 1 device-to-host only, endpoint 2 bidirectional.

Top module: `ep_fifo_bridge`

## Requirements
- R1: A CPU write at offset 2 of an endpoint pushes `cpu_wdata` into that endpoint's IN FIFO. `eng_in_data` shows the front byte of the IN FIFO of `eng_ep`, and a cycle with `eng_in_pop` high removes it.
- R2: `eng_out_push` writes `eng_out_data` into the OUT FIFO of `eng_ep`. A CPU read at offset 3 returns the front byte, or 0 when the FIFO is empty, without removing it. A CPU write at offset 3 removes one byte, and its data is ignored.
- R3: Each FIFO holds `FIFO_DEPTH` (64) bytes. A push to a full FIFO and a pop from an empty FIFO have no effect. When a push and a pop meet in one cycle, each is judged against the occupancy before that clock edge.
- R4: A cycle with `eng_in_done` or `eng_out_done` high sets the pending flag of `eng_ep` at that edge. When the engine sets the flag and the CPU clears it in the same cycle, the set takes precedence.
- R5: The response register at offset 1 holds bits [1:0] with these codes: 0 = ACK, 1 = NAK, 2 = STALL. `eng_resp` carries the handshake for `eng_ep`/`eng_dir_in` without a clock delay, in the same encoding. A stored 3 is reported as NAK, so `eng_resp` never carries 3.
- R6: While an endpoint's pending flag is set, `eng_resp` for that endpoint is NAK, whatever its response register holds.
- R7: A CPU write at offset 0 clears the pending flag when bit 0 is 1 and stores bit 1 as the interrupt enable. `ep_irq[i]` is the pending flag of endpoint i ANDed with its enable, and `irq` is the OR of all `ep_irq` bits.
- R8: A CPU read at offset 0 returns the status: bit 0 pending, bit 1 interrupt enable, bit 2 IN empty, bit 3 IN full, bit 4 OUT empty, bit 5 OUT full, bits 7:6 zero. Offset 2 reads 0.
- R9: A token for a direction the endpoint does not have, or for an index of `NUM_EP` or above, gets STALL. An absent FIFO reads as empty and not full, ignores pushes and pops, and gives 0 on its data outputs.
- R10: `cpu_addr` is {endpoint index, offset[1:0]}. Writes to an index of `NUM_EP` or above are ignored, and reads there return 0. Reset empties all FIFOs, clears every pending flag and enable, and sets every response register to 1 (NAK).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_addr | input | EPW+2 | CPU address {endpoint, offset} |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data for `cpu_addr`, combinational |
| eng_ep | input | EPW | Endpoint addressed by the packet engine |
| eng_dir_in | input | 1 | 1 = device-to-host token, 0 = host-to-device |
| eng_resp | output | 2 | Handshake to return: 0 ACK, 1 NAK, 2 STALL |
| eng_in_pop | input | 1 | Engine consumes one byte from the IN FIFO |
| eng_in_data | output | 8 | Front byte of the selected IN FIFO |
| eng_in_empty | output | 1 | Selected IN FIFO is empty |
| eng_in_done | input | 1 | Device-to-host packet fully transmitted |
| eng_out_push | input | 1 | Engine stores one received byte |
| eng_out_data | input | 8 | Received byte |
| eng_out_done | input | 1 | Host-to-device packet fully received |
| ep_irq | output | NUM_EP | Per-endpoint interrupt lines |
| irq | output | 1 | OR of all endpoint interrupt lines |

## Verification
The bench builds the block with its defaults: three endpoints, the second of them device-to-host only, and 64-byte FIFOs. The depth is small enough to fill a FIFO completely with 65 pushes and to drain it byte by byte, which brings the full, empty and simultaneous push/pop corners within reach. The missing OUT direction on endpoint 1 and the unused index 3 of the two-bit endpoint field exercise the STALL answer and the absent-FIFO behaviour without a second build.

// File: rtl/ep_bridge_pkg.sv
package ep_bridge_pkg;

    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2
    } hs_e;

    // register offsets inside one endpoint window
    localparam logic [1:0] OFF_CTRL     = 2'd0;
    localparam logic [1:0] OFF_RESP     = 2'd1;
    localparam logic [1:0] OFF_IN_HEAD  = 2'd2;
    localparam logic [1:0] OFF_OUT_HEAD = 2'd3;

    // status word, bit 0 is pending
    typedef struct packed {
        logic out_full;
        logic out_empty;
        logic in_full;
        logic in_empty;
        logic irq_en;
        logic pending;
    } ep_stat_t;

    typedef struct packed {
        logic       push_in;
        logic       pop_out;
        logic       ctrl_we;
        logic       resp_we;
        logic [7:0] wdata;
    } cpu_cmd_t;

    typedef struct packed {
        logic       pop_in;
        logic       push_out;
        logic       done;
        logic [7:0] wdata;
    } eng_cmd_t;

    function automatic hs_e resolve_hs(logic dir_ok, logic pending, logic [1:0] code);
        if (!dir_ok)
            return HS_STALL;
        if (pending)
            return HS_NAK;
        case (code)
            2'd0:    return HS_ACK;
            2'd2:    return HS_STALL;
            default: return HS_NAK;
        endcase
    endfunction

endpackage

// File: rtl/ep_byte_fifo.sv
module ep_byte_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] front,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rd_ptr, wr_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= push_data;
    end

    assign front = empty ? '0 : mem[rd_ptr];

endmodule

// File: rtl/ep_channel.sv
module ep_channel
    import ep_bridge_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter bit HAS_IN  = 1'b1,
    parameter bit HAS_OUT = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  cpu_cmd_t   cpu,
    input  eng_cmd_t   eng,
    output ep_stat_t   stat,
    output logic [7:0] in_front,
    output logic [7:0] out_front,
    output logic [1:0] resp_code
);
    logic pending, irq_en;
    logic in_empty, in_full, out_empty, out_full;

    generate
        if (HAS_IN) begin : g_in
            ep_byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
                .clk      (clk),
                .rst      (rst),
                .push     (cpu.push_in),
                .push_data(cpu.wdata),
                .pop      (eng.pop_in),
                .front    (in_front),
                .empty    (in_empty),
                .full     (in_full)
            );
        end else begin : g_no_in
            logic unused_in;
            assign unused_in = ^{cpu.push_in, eng.pop_in};
            assign in_front  = '0;
            assign in_empty  = 1'b1;
            assign in_full   = 1'b0;
        end

        if (HAS_OUT) begin : g_out
            ep_byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
                .clk      (clk),
                .rst      (rst),
                .push     (eng.push_out),
                .push_data(eng.wdata),
                .pop      (cpu.pop_out),
                .front    (out_front),
                .empty    (out_empty),
                .full     (out_full)
            );
        end else begin : g_no_out
            logic unused_out;
            assign unused_out = ^{eng.push_out, eng.wdata, cpu.pop_out};
            assign out_front  = '0;
            assign out_empty  = 1'b1;
            assign out_full   = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pending   <= 1'b0;
            irq_en    <= 1'b0;
            resp_code <= HS_NAK;
        end else begin
            if (cpu.ctrl_we)
                irq_en <= cpu.wdata[1];
            // completion from the engine outranks a CPU clear
            if (eng.done)
                pending <= 1'b1;
            else if (cpu.ctrl_we && cpu.wdata[0])
                pending <= 1'b0;
            if (cpu.resp_we)
                resp_code <= cpu.wdata[1:0];
        end
    end

    assign stat = '{out_full:  out_full,
                    out_empty: out_empty,
                    in_full:   in_full,
                    in_empty:  in_empty,
                    irq_en:    irq_en,
                    pending:   pending};

endmodule

// File: rtl/ep_fifo_bridge.sv
module ep_fifo_bridge
    import ep_bridge_pkg::*;
#(
    parameter int NUM_EP = 3,
    parameter int FIFO_DEPTH = 64,
    // two bits per endpoint: [2i+1] has IN FIFO, [2i] has OUT FIFO
    parameter logic [2*NUM_EP-1:0] EP_KIND = 6'b11_10_11,
    localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
    localparam int AW  = EPW + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_we,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic [EPW-1:0]    eng_ep,
    input  logic              eng_dir_in,
    output logic [1:0]        eng_resp,
    input  logic              eng_in_pop,
    output logic [7:0]        eng_in_data,
    output logic              eng_in_empty,
    input  logic              eng_in_done,
    input  logic              eng_out_push,
    input  logic [7:0]        eng_out_data,
    input  logic              eng_out_done,
    output logic [NUM_EP-1:0] ep_irq,
    output logic              irq
);
    logic [EPW-1:0] cpu_ep;
    logic [1:0]     cpu_off;

    assign cpu_ep  = cpu_addr[AW-1:2];
    assign cpu_off = cpu_addr[1:0];

    ep_stat_t          stat      [NUM_EP];
    logic [7:0]        in_front  [NUM_EP];
    logic [7:0]        out_front [NUM_EP];
    logic [1:0]        resp_code [NUM_EP];
    logic [NUM_EP-1:0] pend_vec, en_vec;

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        cpu_cmd_t ccmd;
        eng_cmd_t ecmd;
        logic     cpu_sel, eng_sel;

        assign cpu_sel = cpu_we && (cpu_ep == EPW'(i));
        assign eng_sel = (eng_ep == EPW'(i));

        assign ccmd.push_in = cpu_sel && (cpu_off == OFF_IN_HEAD);
        assign ccmd.pop_out = cpu_sel && (cpu_off == OFF_OUT_HEAD);
        assign ccmd.ctrl_we = cpu_sel && (cpu_off == OFF_CTRL);
        assign ccmd.resp_we = cpu_sel && (cpu_off == OFF_RESP);
        assign ccmd.wdata   = cpu_wdata;

        assign ecmd.pop_in   = eng_sel && eng_in_pop;
        assign ecmd.push_out = eng_sel && eng_out_push;
        assign ecmd.done     = eng_sel && (eng_in_done || eng_out_done);
        assign ecmd.wdata    = eng_out_data;

        ep_channel #(
            .DEPTH  (FIFO_DEPTH),
            .HAS_IN (EP_KIND[2*i+1]),
            .HAS_OUT(EP_KIND[2*i])
        ) u_ch (
            .clk      (clk),
            .rst      (rst),
            .cpu      (ccmd),
            .eng      (ecmd),
            .stat     (stat[i]),
            .in_front (in_front[i]),
            .out_front(out_front[i]),
            .resp_code(resp_code[i])
        );

        assign pend_vec[i] = stat[i].pending;
        assign en_vec[i]   = stat[i].irq_en;
    end

    assign ep_irq = pend_vec & en_vec;
    assign irq    = |ep_irq;

    // CPU read path
    always_comb begin
        cpu_rdata = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (cpu_ep == EPW'(i)) begin
                case (cpu_off)
                    OFF_CTRL:     cpu_rdata = {2'b00, stat[i]};
                    OFF_RESP:     cpu_rdata = {6'b0, resp_code[i]};
                    OFF_OUT_HEAD: cpu_rdata = out_front[i];
                    default:      cpu_rdata = '0;
                endcase
            end
        end
    end

    // engine-side selection
    logic       dir_ok, pend_sel;
    logic [1:0] code_sel;

    always_comb begin
        eng_in_data  = '0;
        eng_in_empty = 1'b1;
        dir_ok       = 1'b0;
        pend_sel     = 1'b0;
        code_sel     = HS_NAK;
        for (int i = 0; i < NUM_EP; i++) begin
            if (eng_ep == EPW'(i)) begin
                eng_in_data  = in_front[i];
                eng_in_empty = stat[i].in_empty;
                dir_ok       = eng_dir_in ? EP_KIND[2*i+1] : EP_KIND[2*i];
                pend_sel     = pend_vec[i];
                code_sel     = resp_code[i];
            end
        end
    end

    assign eng_resp = resolve_hs(dir_ok, pend_sel, code_sel);

endmodule

// File: rtl/ep_fifo_bridge_chk.sv
module ep_fifo_bridge_chk
    import ep_bridge_pkg::*;
#(
    parameter int NUM_EP = 3,
    parameter int EPW = 2,
    parameter logic [2*NUM_EP-1:0] EP_KIND = 6'b11_10_11
) (
    input logic              clk,
    input logic              rst,
    input logic [EPW-1:0]    eng_ep,
    input logic              eng_dir_in,
    input logic              eng_in_done,
    input logic              eng_out_done,
    input logic              cpu_we,
    input logic [1:0]        eng_resp,
    input logic              irq,
    input logic [NUM_EP-1:0] pend_vec
);
    logic           ep_ok, dir_has, sel_pend;
    logic [EPW-1:0] ep_q;

    always_comb begin
        ep_ok    = 1'b0;
        dir_has  = 1'b0;
        sel_pend = 1'b0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (eng_ep == EPW'(i)) begin
                ep_ok    = 1'b1;
                dir_has  = eng_dir_in ? EP_KIND[2*i+1] : EP_KIND[2*i];
                sel_pend = pend_vec[i];
            end
        end
    end

    always_ff @(posedge clk) ep_q <= eng_ep;

    assert_no_code3_R5: assert property (@(posedge clk) disable iff (rst)
        eng_resp != 2'd3);

    assert_pending_nak_R6: assert property (@(posedge clk) disable iff (rst)
        (dir_has && sel_pend) |-> (eng_resp == HS_NAK));

    assert_absent_stall_R9: assert property (@(posedge clk) disable iff (rst)
        !dir_has |-> (eng_resp == HS_STALL));

    assert_done_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (ep_ok && (eng_in_done || eng_out_done)) |=> pend_vec[ep_q]);

    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(eng_in_done || eng_out_done || cpu_we));

endmodule

bind ep_fifo_bridge ep_fifo_bridge_chk #(
    .NUM_EP (NUM_EP),
    .EPW    (EPW),
    .EP_KIND(EP_KIND)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .eng_ep      (eng_ep),
    .eng_dir_in  (eng_dir_in),
    .eng_in_done (eng_in_done),
    .eng_out_done(eng_out_done),
    .cpu_we      (cpu_we),
    .eng_resp    (eng_resp),
    .irq         (irq),
    .pend_vec    (pend_vec)
);

// File: tb/ep_fifo_bridge_test.sv
module ep_fifo_bridge_test;
    localparam int NEP = 3;
    localparam int DEP = 64;
    localparam logic [5:0] KIND = 6'b11_10_11;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_we;
    logic [3:0] cpu_addr;
    logic [7:0] cpu_wdata, cpu_rdata;
    logic [1:0] eng_ep;
    logic       eng_dir_in;
    logic [1:0] eng_resp;
    logic       eng_in_pop, eng_in_empty, eng_in_done;
    logic [7:0] eng_in_data;
    logic       eng_out_push, eng_out_done;
    logic [7:0] eng_out_data;
    logic [2:0] ep_irq;
    logic       irq;

    ep_fifo_bridge uut (
        .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .eng_ep(eng_ep),
        .eng_dir_in(eng_dir_in), .eng_resp(eng_resp), .eng_in_pop(eng_in_pop),
        .eng_in_data(eng_in_data), .eng_in_empty(eng_in_empty),
        .eng_in_done(eng_in_done), .eng_out_push(eng_out_push),
        .eng_out_data(eng_out_data), .eng_out_done(eng_out_done),
        .ep_irq(ep_irq), .irq(irq)
    );

    always #4ns clk = ~clk;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [7:0] inq  [NEP][$];
    logic [7:0] outq [NEP][$];
    bit         pend [NEP];
    bit         en   [NEP];
    logic [1:0] rsp  [NEP];

    function automatic bit has_in(int e);
        return KIND[2*e+1];
    endfunction
    function automatic bit has_out(int e);
        return KIND[2*e];
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < NEP; e++) begin
                inq[e].delete();
                outq[e].delete();
                pend[e] = 1'b0;
                en[e]   = 1'b0;
                rsp[e]  = 2'd1;
            end
        end else begin
            int ce, off, eg;
            bit pu, po;
            ce  = int'(cpu_addr[3:2]);
            off = int'(cpu_addr[1:0]);
            eg  = int'(eng_ep);
            if (cpu_we && ce < NEP) begin
                if (off == 0) begin
                    en[ce] = cpu_wdata[1];
                    if (cpu_wdata[0]) pend[ce] = 1'b0;
                end
                if (off == 1) rsp[ce] = cpu_wdata[1:0];
            end
            if ((eng_in_done || eng_out_done) && eg < NEP) pend[eg] = 1'b1;
            for (int e = 0; e < NEP; e++) begin
                pu = cpu_we && ce == e && off == 2 && has_in(e) && inq[e].size() < DEP;
                po = eng_in_pop && eg == e && has_in(e) && inq[e].size() > 0;
                if (po) void'(inq[e].pop_front());
                if (pu) inq[e].push_back(cpu_wdata);
                pu = eng_out_push && eg == e && has_out(e) && outq[e].size() < DEP;
                po = cpu_we && ce == e && off == 3 && has_out(e) && outq[e].size() > 0;
                if (po) void'(outq[e].pop_front());
                if (pu) outq[e].push_back(eng_out_data);
            end
        end
    end

    task automatic compare_all();
        int ce, off, eg;
        logic [7:0] er, ed;
        logic [1:0] es;
        logic [2:0] ei;
        string rt, st;
        ce  = int'(cpu_addr[3:2]);
        off = int'(cpu_addr[1:0]);
        eg  = int'(eng_ep);
        er  = 8'h00;
        rt  = "R10";
        if (ce < NEP) begin
            case (off)
                0: begin
                    rt = "R8";
                    er = {2'b00,
                          has_out(ce) && outq[ce].size() == DEP,
                          !(has_out(ce) && outq[ce].size() > 0),
                          has_in(ce) && inq[ce].size() == DEP,
                          !(has_in(ce) && inq[ce].size() > 0),
                          en[ce], pend[ce]};
                end
                1: begin rt = "R5"; er = {6'b0, rsp[ce]}; end
                3: begin
                    rt = "R2";
                    er = (has_out(ce) && outq[ce].size() > 0) ? outq[ce][0] : 8'h00;
                end
                default: rt = "R8";
            endcase
        end
        check(rt, "cpu_rdata", cpu_rdata, er);

        ed = 8'h00;
        if (eg >= NEP) begin
            es = 2'd2; st = "R9";
        end else if (!(eng_dir_in ? has_in(eg) : has_out(eg))) begin
            es = 2'd2; st = "R9";
        end else if (pend[eg]) begin
            es = 2'd1; st = "R6";
        end else begin
            es = (rsp[eg] == 2'd3) ? 2'd1 : rsp[eg]; st = "R5";
        end
        check(st, "eng_resp", eng_resp, es);
        if (eg < NEP && has_in(eg) && inq[eg].size() > 0) ed = inq[eg][0];
        check("R1", "eng_in_data", eng_in_data, ed);
        check("R1", "eng_in_empty", eng_in_empty, ed === 8'h00 &&
              !(eg < NEP && has_in(eg) && inq[eg].size() > 0));
        for (int e = 0; e < NEP; e++) ei[e] = pend[e] && en[e];
        check("R7", "ep_irq", ep_irq, ei);
        check("R7", "irq", irq, |ei);
    endtask

    always @(negedge clk) begin
        #1ns;
        if (!rst) compare_all();
    end

    task automatic idle();
        cpu_we       = 1'b0;
        eng_in_pop   = 1'b0;
        eng_out_push = 1'b0;
        eng_in_done  = 1'b0;
        eng_out_done = 1'b0;
    endtask

    task automatic cpu_wr(int ep, int off, logic [7:0] d);
        @(negedge clk);
        idle();
        cpu_we    = 1'b1;
        cpu_addr  = 4'(ep * 4 + off);
        cpu_wdata = d;
    endtask

    task automatic cpu_peek(int ep, int off, logic [7:0] exp, string req);
        @(negedge clk);
        idle();
        cpu_addr = 4'(ep * 4 + off);
        #2ns;
        check(req, "register read", cpu_rdata, exp);
    endtask

    task automatic eng_push(int ep, logic [7:0] d);
        @(negedge clk);
        idle();
        eng_ep       = 2'(ep);
        eng_out_push = 1'b1;
        eng_out_data = d;
    endtask

    task automatic eng_pop(int ep);
        @(negedge clk);
        idle();
        eng_ep     = 2'(ep);
        eng_in_pop = 1'b1;
    endtask

    task automatic eng_front(int ep, logic [7:0] exp, string req);
        @(negedge clk);
        idle();
        eng_ep = 2'(ep);
        #2ns;
        check(req, "engine front", eng_in_data, exp);
    endtask

    task automatic tok(int ep, bit din, logic [1:0] exp, string req);
        @(negedge clk);
        idle();
        eng_ep     = 2'(ep);
        eng_dir_in = din;
        #2ns;
        check(req, "handshake", eng_resp, exp);
    endtask

    initial begin
        idle();
        cpu_addr = '0; cpu_wdata = '0; eng_ep = '0; eng_dir_in = 1'b0; eng_out_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        cpu_peek(0, 0, 8'h14, "R10");
        cpu_peek(1, 0, 8'h14, "R10");
        cpu_peek(2, 1, 8'h01, "R10");
        check("R10", "irq after reset", irq, 1'b0);
        cpu_wr(3, 1, 8'h02);
        cpu_peek(3, 1, 8'h00, "R10");

        // R1 push and engine drain
        cpu_wr(0, 2, 8'hA5);
        cpu_wr(0, 2, 8'h3C);
        eng_front(0, 8'hA5, "R1");
        eng_pop(0);
        eng_front(0, 8'h3C, "R1");
        cpu_peek(0, 2, 8'h00, "R8");
        eng_pop(0);
        eng_front(0, 8'h00, "R1");

        // R3 fill IN FIFO of endpoint 1
        for (int i = 0; i <= DEP; i++) cpu_wr(1, 2, 8'(i));
        cpu_peek(1, 0, 8'h18, "R3");
        for (int i = 0; i < DEP; i++) begin
            eng_front(1, 8'(i), "R3");
            eng_pop(1);
        end
        eng_pop(1);
        cpu_peek(1, 0, 8'h14, "R3");
        cpu_wr(1, 2, 8'h07);
        eng_front(1, 8'h07, "R3");
        eng_pop(1);

        // R3 simultaneous push/pop on endpoint 0 IN
        cpu_wr(0, 2, 8'h11);
        eng_ep = 2'd0; eng_in_pop = 1'b1;
        eng_front(0, 8'h11, "R3");
        cpu_wr(0, 2, 8'h22);
        eng_ep = 2'd0; eng_in_pop = 1'b1;
        eng_front(0, 8'h22, "R3");
        for (int i = 0; i < DEP - 1; i++) cpu_wr(0, 2, 8'(8'h40 + i));
        cpu_peek(0, 0, 8'h18, "R3");
        cpu_wr(0, 2, 8'hEE);
        eng_ep = 2'd0; eng_in_pop = 1'b1;
        cpu_peek(0, 0, 8'h10, "R3");
        for (int i = 0; i < DEP - 1; i++) eng_pop(0);
        cpu_peek(0, 0, 8'h14, "R3");

        // R2 OUT path on endpoint 2
        eng_push(2, 8'h81);
        eng_push(2, 8'h82);
        eng_push(2, 8'h83);
        @(negedge clk); idle(); eng_ep = 2'd2; eng_out_done = 1'b1;
        cpu_peek(2, 3, 8'h81, "R2");
        cpu_peek(2, 3, 8'h81, "R2");
        cpu_wr(2, 3, 8'hFF);
        cpu_peek(2, 3, 8'h82, "R2");
        cpu_peek(2, 0, 8'h05, "R4");

        // R6 pending forces NAK, R5 codes
        cpu_wr(2, 1, 8'h00);
        tok(2, 1'b0, 2'd1, "R6");
        cpu_wr(2, 0, 8'h01);
        tok(2, 1'b0, 2'd0, "R5");
        cpu_wr(2, 1, 8'h02);
        tok(2, 1'b1, 2'd2, "R5");
        cpu_wr(2, 1, 8'h03);
        tok(2, 1'b1, 2'd1, "R5");

        // R4 set beats clear, R7 interrupt enable
        @(negedge clk); idle();
        eng_ep = 2'd2; eng_in_done = 1'b1;
        cpu_we = 1'b1; cpu_addr = 4'(2 * 4 + 0); cpu_wdata = 8'h01;
        cpu_peek(2, 0, 8'h05, "R4");
        cpu_wr(2, 0, 8'h02);
        @(negedge clk); idle(); #2ns;
        check("R7", "ep_irq enabled", ep_irq, 3'b100);
        check("R7", "irq enabled", irq, 1'b1);
        cpu_wr(2, 0, 8'h03);
        @(negedge clk); idle(); #2ns;
        check("R7", "irq after clear", irq, 1'b0);
        cpu_peek(2, 0, 8'h06, "R7");

        // R9 absent direction and index
        tok(1, 1'b0, 2'd2, "R9");
        tok(3, 1'b1, 2'd2, "R9");
        eng_front(3, 8'h00, "R9");
        eng_push(1, 8'h55);
        cpu_peek(1, 3, 8'h00, "R9");
        cpu_peek(1, 0, 8'h14, "R9");
        @(negedge clk); idle(); eng_ep = 2'd3; eng_out_done = 1'b1;
        cpu_peek(0, 0, 8'h14, "R10");

        // R3 fill OUT FIFO of endpoint 0 and drain through the CPU
        for (int i = 0; i <= DEP; i++) eng_push(0, 8'(8'h80 + i));
        cpu_peek(0, 0, 8'h24, "R3");
        for (int i = 0; i < DEP; i++) begin
            cpu_peek(0, 3, 8'(8'h80 + i), "R2");
            cpu_wr(0, 3, 8'h00);
        end
        cpu_wr(0, 3, 8'h00);
        cpu_peek(0, 0, 8'h14, "R3");

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule